// File: doc/BRIEF.md
# Serial-In Parallel-Out Display Driver Controller

This block holds the logic side of a 32-channel driver for high-voltage display or print-head outputs. A serial bit stream is clocked into a chain of stages by the falling edge of a separate shift clock. The last stage is brought out as a cascade pin so that several controllers can be chained from one data line. A latch-enable input copies the chain into a bank of output latches. It copies continuously while high and holds once it drops. Two control inputs, `show` and `pol`, then pick one of four output modes: every channel forced on, every channel forced off, the latched pattern inverted, or the latched pattern passed straight through.

The shift clock, serial data and latch enable come from slow external sources. They are brought into the fast system clock domain through a parameterised synchronizer. The shift-clock falling edge is detected there, so every register in the block runs on one clock. The drive outputs are registered. A build parameter chooses whether the first stage of the chain feeds output 0 or output CHANNELS-1, which mirrors the channel order for boards wired in the opposite direction.

Top module: `s2p_driver`

## Requirements
- R1: Each falling edge of `sclk` moves the chain one stage: stage 0 takes `sdin`, and stage k takes the old stage k-1. A rising edge of `sclk` moves nothing.
- R2: `sdout` always shows the last stage. A bit shifted in therefore appears on `sdout` after CHANNELS falling edges.
- R3: While `le` is high, the latches follow the chain, so the outputs track each shift.
- R4: While `le` is low, the latches hold the value they had when `le` fell. Shifting does not change `drv_out`.
- R5: With `show`=0 and `pol`=0, every bit of `drv_out` is 1 (on), whatever the latches hold.
- R6: With `show`=0 and `pol`=1, every bit of `drv_out` is 0 (off), whatever the latches hold.
- R7: With `show`=1 and `pol`=0, each output bit is the inverse of its mapped latch bit.
- R8: With `show`=1 and `pol`=1, each output bit equals its mapped latch bit.
- R9: With REVERSE=0, `drv_out[j]` is mapped from latch stage j. With REVERSE=1, it is mapped from latch stage CHANNELS-1-j. Stage 0 is the input stage.
- R10: A synchronous high `rst` clears the chain, the latches and `drv_out` to zero.
- R11: A change on `show` or `pol` reaches `drv_out` without any `sclk` or `le` activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Shift clock; the chain advances on its falling edge |
| sdin | input | 1 | Serial data into stage 0 |
| le | input | 1 | Latch enable; high = transparent, low = hold |
| show | input | 1 | 0 forces all outputs, 1 shows the pattern |
| pol | input | 1 | Selects on/off when forced, inversion when shown |
| sdout | output | 1 | Cascade output, last stage of the chain |
| drv_out | output | CHANNELS | Registered channel drive levels, 1 = on |

## Verification
The hardest state to reach is one where the latches and the chain differ. That needs a latch pulse followed by further shifting with `le` low. Only then can hold behaviour be told apart from transparency. The stimulus loads a known pattern and pulses `le`. It then shifts a second pattern with `le` low and checks that `drv_out` still shows the first pattern in every mode. Random rounds mix held and transparent loads with random mode changes. A second instance built with REVERSE=1 shares all inputs, so the mirrored mapping is checked on the same stimulus.

// File: rtl/s2p_pkg.sv
package s2p_pkg;
  typedef enum logic [1:0] {
    MODE_ALL_ON  = 2'b00,
    MODE_ALL_OFF = 2'b01,
    MODE_INVERT  = 2'b10,
    MODE_PASS    = 2'b11
  } mode_t;

  function automatic mode_t mode_of(input logic show, input logic pol);
    return mode_t'({show, pol});
  endfunction
endpackage

// File: rtl/s2p_sync.sv
module s2p_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/s2p_shift.sv
module s2p_shift #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         din,
  output logic [N-1:0] stages
);
  always_ff @(posedge clk) begin
    if (rst)       stages <= '0;
    else if (step) stages <= {stages[N-2:0], din};
  end

  // R1: one stage per detected falling edge, nothing otherwise
  assert_shift_moves_R1: assert property (@(posedge clk) disable iff (rst)
    step |=> (stages[0] == $past(din)) && (stages[N-1:1] == $past(stages[N-2:0])));
  assert_shift_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(stages));
endmodule

// File: rtl/s2p_hold.sv
module s2p_hold #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         open,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (open) q <= d;
  end

  assert_latch_follows_R3: assert property (@(posedge clk) disable iff (rst)
    open |=> q == $past(d));
  assert_latch_holds_R4: assert property (@(posedge clk) disable iff (rst)
    !open |=> $stable(q));
endmodule

// File: rtl/s2p_drive.sv
module s2p_drive
  import s2p_pkg::*;
#(
  parameter int N       = 32,
  parameter bit REVERSE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         show,
  input  logic         pol,
  input  logic [N-1:0] latch_q,
  output logic [N-1:0] drv_out
);
  mode_t       mode;
  logic [N-1:0] mapped;
  logic [N-1:0] nxt;

  genvar j;
  generate
    if (REVERSE) begin : g_rev
      for (j = 0; j < N; j++) begin : g_bit
        assign mapped[j] = latch_q[N-1-j];
      end
    end else begin : g_fwd
      assign mapped = latch_q;
    end
  endgenerate

  assign mode = mode_of(show, pol);

  always_comb begin
    case (mode)
      MODE_ALL_ON:  nxt = '1;
      MODE_ALL_OFF: nxt = '0;
      MODE_INVERT:  nxt = ~mapped;
      default:      nxt = mapped;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) drv_out <= '0;
    else     drv_out <= nxt;
  end

  assert_all_on_R5: assert property (@(posedge clk) disable iff (rst)
    (!show && !pol) |=> drv_out == '1);
  assert_all_off_R6: assert property (@(posedge clk) disable iff (rst)
    (!show && pol) |=> drv_out == '0);
  assert_invert_R7: assert property (@(posedge clk) disable iff (rst)
    (show && !pol) |=> drv_out == ~$past(latch_q[N-1] ? mapped : mapped));
endmodule

// File: rtl/s2p_driver.sv
module s2p_driver #(
  parameter int CHANNELS    = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit REVERSE     = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk,
  input  logic                sdin,
  input  logic                le,
  input  logic                show,
  input  logic                pol,
  output logic                sdout,
  output logic [CHANNELS-1:0] drv_out
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0]   sync_q;
  logic                sclk_s, sdin_s, le_s;
  logic                sclk_prev;
  logic                fall;
  logic [CHANNELS-1:0] chain;
  logic [CHANNELS-1:0] latched;

  s2p_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk, sdin, le}),
    .q   (sync_q)
  );
  assign {sclk_s, sdin_s, le_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_s;
  end
  assign fall = sclk_prev & ~sclk_s;

  s2p_shift #(.N(CHANNELS)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .step   (fall),
    .din    (sdin_s),
    .stages (chain)
  );

  s2p_hold #(.N(CHANNELS)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .open (le_s),
    .d    (chain),
    .q    (latched)
  );

  s2p_drive #(.N(CHANNELS), .REVERSE(REVERSE)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .show    (show),
    .pol     (pol),
    .latch_q (latched),
    .drv_out (drv_out)
  );

  assign sdout = chain[CHANNELS-1];

  // R2: a rising shift clock never moves the cascade output
  assert_cascade_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (sclk_s && !sclk_prev) |=> $stable(sdout));
endmodule

// File: tb/s2p_driver_bench.sv
module s2p_driver_bench;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst, sclk, sdin, le, show, pol;
  logic sdout, sdout_r;
  logic [N-1:0] drv, drv_r;

  logic [N-1:0] m_sr, m_lat;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  s2p_driver #(.CHANNELS(N), .REVERSE(1'b0)) u_s2p_driver (
    .clk(clk), .rst(rst), .sclk(sclk), .sdin(sdin), .le(le),
    .show(show), .pol(pol), .sdout(sdout), .drv_out(drv));

  s2p_driver #(.CHANNELS(N), .REVERSE(1'b1)) u_s2p_driver_rev (
    .clk(clk), .rst(rst), .sclk(sclk), .sdin(sdin), .le(le),
    .show(show), .pol(pol), .sdout(sdout_r), .drv_out(drv_r));

  function automatic logic [N-1:0] expect_out(input logic [N-1:0] lat, input logic sh,
                                               input logic pl, input bit rev);
    logic [N-1:0] mp;
    for (int j = 0; j < N; j++) mp[j] = rev ? lat[N-1-j] : lat[j];
    case ({sh, pl})
      2'b00:   return '1;
      2'b01:   return '0;
      2'b10:   return ~mp;
      default: return mp;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_outs(input string req);
    logic [N-1:0] e0, e1;
    e0 = expect_out(m_lat, show, pol, 1'b0);
    e1 = expect_out(m_lat, show, pol, 1'b1);
    chk(drv === e0, req, drv, e0);
    chk(drv_r === e1, {req, "/R9"}, drv_r, e1);
  endtask

  task automatic shift_bit(input logic b);
    sdin = b;
    sclk = 1'b1;
    settle(5);
    // R1: rising edge alone moves nothing
    chk(sdout === m_sr[N-1], "R1 rise", {{(N-1){1'b0}}, sdout}, {{(N-1){1'b0}}, m_sr[N-1]});
    sclk = 1'b0;
    settle(6);
    m_sr = {m_sr[N-2:0], b};
    if (le) m_lat = m_sr;
  endtask

  task automatic shift_word(input logic [N-1:0] w, input bit per_bit_check);
    for (int i = N - 1; i >= 0; i--) begin
      shift_bit(w[i]);
      if (per_bit_check)
        chk(sdout === m_sr[N-1], "R2 cascade", {{(N-1){1'b0}}, sdout},
            {{(N-1){1'b0}}, m_sr[N-1]});
    end
  endtask

  task automatic pulse_le();
    le = 1'b1;
    settle(6);
    m_lat = m_sr;
    le = 1'b0;
    settle(6);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    settle(6);
    rst = 1'b0;
    settle(2);
    m_sr = '0;
    m_lat = '0;
  endtask

  initial begin
    #1500000;
    $display("FAIL watchdog expired actual=running expected=done");
    fails++;
    checks++;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; sclk = 1'b0; sdin = 1'b0; le = 1'b0; show = 1'b1; pol = 1'b1;
    m_sr = '0; m_lat = '0;
    settle(2);
    do_reset();
    // R10: reset state
    chk(drv === '0, "R10 reset drv", drv, '0);
    chk(sdout === 1'b0, "R10 reset sdout", {{(N-1){1'b0}}, sdout}, '0);

    // R2: known pattern, cascade bit by bit; R4: outputs hold with le low
    shift_word(32'hA5C3_0F96, 1'b1);
    check_outs("R4 hold during shift");
    shift_word(32'h8000_0001, 1'b1);
    pulse_le();
    check_outs("R8 pass after load");

    // R4: shift a new word with le low; latches keep the old one
    shift_word(32'h1234_5678, 1'b0);
    check_outs("R4 hold after shift");

    // R5..R8, R11: mode changes with no sclk or le activity
    show = 1'b0; pol = 1'b0; settle(2); check_outs("R5 all on R11");
    show = 1'b0; pol = 1'b1; settle(2); check_outs("R6 all off R11");
    show = 1'b1; pol = 1'b0; settle(2); check_outs("R7 invert R11");
    show = 1'b1; pol = 1'b1; settle(2); check_outs("R8 pass R11");

    // R3: transparent latch follows every shift
    le = 1'b1;
    settle(6);
    m_lat = m_sr;
    for (int i = 0; i < 8; i++) begin
      shift_bit(i[0] ^ i[2]);
      check_outs("R3 transparent");
    end
    le = 1'b0;
    settle(6);
    shift_bit(1'b1);
    shift_bit(1'b0);
    check_outs("R4 hold after le fall");

    // random rounds
    for (int r = 0; r < 24; r++) begin
      logic [N-1:0] w;
      w = $urandom;
      shift_word(w, r < 4);
      if ($urandom_range(0, 1) == 0) pulse_le();
      show = 1'($urandom_range(0, 1));
      pol  = 1'($urandom_range(0, 1));
      settle(2);
      check_outs("R5-8 random");
    end

    // R10: reset mid-run clears everything
    show = 1'b1; pol = 1'b0;
    do_reset();
    show = 1'b1; pol = 1'b1;
    settle(2);
    chk(drv === '0, "R10 mid reset drv", drv, '0);
    chk(sdout === 1'b0, "R10 mid reset sdout", {{(N-1){1'b0}}, sdout}, '0);
    pulse_le();
    check_outs("R10 chain cleared");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule